// File: doc/BRIEF.md
# Clock-Master Synchronous Serial Receiver

This block receives serial words as the clock master of a synchronous link. The shift clock goes out on `sclk_o`, and a remote sender drives `sdata_i` in step with it. The shift clock runs only while a receive is active. Its rate comes from a programmable divisor. Each received bit is taken in on the trailing edge of a clock period, least significant bit first. A word is 8 bits, or 9 bits when the ninth-bit mode is on.

Software starts a receive through a small register port, using one of two enables. The one-shot enable takes in exactly one word and then clears itself. The streaming enable keeps taking in words back to back until software clears it. When both enables are set, streaming wins. Each finished word is loaded into a holding register and sets a ready flag, which can raise `irq_o`. If a word finishes while the previous one is still unread, the block reports an overrun and halts the clock until software clears the streaming enable.

Top module: `sync_master_rx`

## Requirements
- R1: While no receive is running, `sclk_o` rests at its idle level. Once running, it toggles every divisor+1 system clock cycles, so one bit period is 2*(divisor+1) cycles.
- R2: Polarity bit CTRL[3] sets the idle level of `sclk_o`: 0 gives idle low, 1 gives idle high.
- R3: A bit is sampled from `sdata_i` at each trailing edge (the move back to the idle level), least significant bit first. In 8-bit mode, the DATA register (address 2) returns the 8 sampled bits.
- R4: When CTRL[2] is 1, words are 9 bits. The last sampled bit appears in STAT[2] (address 1) and the first eight appear in DATA. In 8-bit mode STAT[2] reads 0.
- R5: The divisor is DIVL (address 3) alone when CTRL[4] is 0, and {DIVH (address 4), DIVL} when CTRL[4] is 1.
- R6: The one-shot enable CTRL[0] takes in exactly one word, and the hardware then clears CTRL[0].
- R7: The streaming enable CTRL[1] takes in words back to back while it is set. When CTRL[0] and CTRL[1] are both set, streaming applies and CTRL[0] is left set after each word.
- R8: A finished word loads DATA and sets the ready flag STAT[0]. `irq_o` equals STAT[0] AND the interrupt enable CTRL[5]. A read of DATA clears STAT[0].
- R9: A word that finishes while STAT[0] is still set is discarded, sets overrun STAT[1] and stops the shift clock. DATA keeps the older word. A CTRL write with bit 1 equal to 0 clears STAT[1].
- R10: Clearing both enables in the middle of a word stops the clock at its idle level and drops the partial bits. The next receive starts from bit 0.
- R11: After reset, CTRL, STAT, DATA and both divisor bytes read 0, and `sclk_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of DATA clears the ready flag) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from the address |
| sclk_o | output | 1 | Generated shift clock |
| sdata_i | input | 1 | Serial data from the sender |
| irq_o | output | 1 | Receive interrupt |

## Verification
The one-shot path is driven by a table of words that mixes polarity, word length, divisor width and divisor value. A wrong bit order, a lost ninth bit, a polarity that is not applied and a divisor byte that is not ignored each produce a different wrong DATA or STAT value. The bench measures the half period directly for a narrow divisor and for a wide divisor, using the same divisor bytes, which shows whether DIVH is honoured or ignored. Streaming is tried three ways:
- with prompt reads, to check words arriving back to back;
- with no reads, to force an overrun;
- with both enables set, to check precedence.

An abort in the middle of a word, followed by a fresh one-shot word, shows whether leftover partial bits corrupt the next word.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_DATA = 3'd2,
        A_DIVL = 3'd3,
        A_DIVH = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_CONT   = 2'd2
    } rx_mode_e;

    // control byte: [0] one-shot, [1] streaming, [2] ninth bit,
    // [3] clock polarity, [4] wide divisor, [5] irq enable, [7:6] spare
    typedef struct packed {
        logic [1:0] spare;
        logic       irq_en;
        logic       wide;
        logic       pol;
        logic       nine;
        logic       cont;
        logic       single;
    } ctrl_t;

    // streaming has precedence over one-shot
    function automatic rx_mode_e pick_mode(input ctrl_t c);
        if (c.cont)
            return MODE_CONT;
        else if (c.single)
            return MODE_SINGLE;
        return MODE_IDLE;
    endfunction

    function automatic logic [2*BUS_W-1:0] eff_div(input logic wide,
                                                   input logic [BUS_W-1:0] hi,
                                                   input logic [BUS_W-1:0] lo);
        return wide ? {hi, lo} : {{BUS_W{1'b0}}, lo};
    endfunction

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             ph_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             ph_q;
    logic             wrap;

    assign wrap = (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ph_o   = ph_q;
    assign fall_o = run && wrap && ph_q;
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            fall,
    input  logic            nine,
    input  logic            din,
    output logic            done_o,
    output logic [DATA_W:0] word_o
);
    localparam int SH_W   = DATA_W + 1;
    localparam int BCNT_W = $clog2(SH_W + 1);
    localparam logic [BCNT_W-1:0] LAST9 = BCNT_W'(SH_W - 1);
    localparam logic [BCNT_W-1:0] LAST8 = BCNT_W'(SH_W - 2);

    logic [SH_W-1:0]   sh_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [SH_W-1:0]   sh_nxt;
    logic              last;

    assign sh_nxt = {din, sh_q[SH_W-1:1]};
    assign last   = (bcnt_q == (nine ? LAST9 : LAST8));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sh_q   <= '0;
            bcnt_q <= '0;
        end else if (fall) begin
            sh_q   <= sh_nxt;
            bcnt_q <= last ? '0 : bcnt_q + 1'b1;
        end
    end

    assign done_o = fall && last;
    assign word_o = nine ? sh_nxt : {1'b0, sh_nxt[SH_W-1:1]};
endmodule

// File: rtl/srx_regs.sv
module srx_regs
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic                 done,
    input  logic [DATA_W:0]      word,
    output ctrl_t                ctrl_o,
    output logic [2*BUS_W-1:0]   div_o,
    output logic                 run_o,
    output logic                 flag_o,
    output logic                 ovr_o,
    output logic [DATA_W-1:0]    hold_o,
    output logic                 irq_o
);
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_DATA = ADDR_W'(A_DATA);
    localparam logic [ADDR_W-1:0] AD_DIVL = ADDR_W'(A_DIVL);
    localparam logic [ADDR_W-1:0] AD_DIVH = ADDR_W'(A_DIVH);

    ctrl_t             ctrl_q;
    logic [BUS_W-1:0]  divl_q, divh_q;
    logic [DATA_W-1:0] hold_q;
    logic              ninth_q, flag_q, ovr_q;
    rx_mode_e          mode;

    assign mode = pick_mode(ctrl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            divl_q  <= '0;
            divh_q  <= '0;
            hold_q  <= '0;
            ninth_q <= 1'b0;
            flag_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    AD_CTRL: begin
                        ctrl_q <= ctrl_t'(bus_wdata);
                        if (!bus_wdata[1])
                            ovr_q <= 1'b0;
                    end
                    AD_DIVL: divl_q <= bus_wdata;
                    AD_DIVH: divh_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (bus_rd && bus_addr == AD_DATA)
                flag_q <= 1'b0;
            if (done) begin
                if (mode == MODE_SINGLE)
                    ctrl_q.single <= 1'b0;
                if (flag_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    hold_q  <= word[DATA_W-1:0];
                    ninth_q <= word[DATA_W];
                    flag_q  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (bus_addr)
            AD_CTRL: bus_rdata = ctrl_q;
            AD_STAT: bus_rdata = BUS_W'({ninth_q, ovr_q, flag_q});
            AD_DATA: bus_rdata = BUS_W'(hold_q);
            AD_DIVL: bus_rdata = divl_q;
            AD_DIVH: bus_rdata = divh_q;
            default: bus_rdata = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign div_o  = eff_div(ctrl_q.wide, divh_q, divl_q);
    assign run_o  = (mode != MODE_IDLE) && !ovr_q;
    assign flag_o = flag_q;
    assign ovr_o  = ovr_q;
    assign hold_o = hold_q;
    assign irq_o  = flag_q && ctrl_q.irq_en;
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              sclk_o,
    input  logic              sdata_i,
    output logic              irq_o
);
    localparam int DIV_W = 2 * BUS_W;

    ctrl_t             ctrl;
    logic [DIV_W-1:0]  div;
    logic              run, ph, fall, done, flag, ovr;
    logic [DATA_W:0]   word;
    logic [DATA_W-1:0] hold;

    srx_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done), .word(word), .ctrl_o(ctrl), .div_o(div), .run_o(run),
        .flag_o(flag), .ovr_o(ovr), .hold_o(hold), .irq_o(irq_o)
    );

    srx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .run(run), .div(div), .ph_o(ph), .fall_o(fall)
    );

    srx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .run(run), .fall(fall), .nine(ctrl.nine),
        .din(sdata_i), .done_o(done), .word_o(word)
    );

    assign sclk_o = ph ^ ctrl.pol;
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              sclk,
    input logic              pol,
    input logic              single,
    input logic              cont,
    input logic              done,
    input logic              flag,
    input logic              ovr,
    input logic [DATA_W-1:0] hold,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr
);
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(srx_pkg::A_CTRL);
    localparam logic [ADDR_W-1:0] AD_DATA = ADDR_W'(srx_pkg::A_DATA);

    logic ctrl_wr;
    assign ctrl_wr = bus_wr && bus_addr == AD_CTRL;

    p_idle_level_r1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (sclk == pol));

    p_single_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (done && single && !cont && !ctrl_wr) |=> !single);

    p_cont_keeps_single_r7: assert property (@(posedge clk) disable iff (rst)
        (done && single && cont && !ctrl_wr) |=> single);

    p_read_clears_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == AD_DATA && !done) |=> !flag);

    p_ovr_holds_data_r9: assert property (@(posedge clk) disable iff (rst)
        ovr |=> $stable(hold));

    p_ovr_no_word_r9: assert property (@(posedge clk) disable iff (rst)
        ovr |-> !done);
endmodule

bind sync_master_rx srx_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .run(run), .sclk(sclk_o), .pol(ctrl.pol),
    .single(ctrl.single), .cont(ctrl.cont), .done(done), .flag(flag),
    .ovr(ovr), .hold(hold), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr)
);

// File: tb/sync_master_rx_tb_top.sv
module sync_master_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk, irq;
    logic       sdata = 1'b0;

    int checks = 0, fails = 0;
    int cyc = 0;
    bit done_flag = 0;

    // sender model state
    logic [8:0] sl_words [8];
    int         sl_idx = 0, sl_bit = 0, sl_nbits = 8;
    logic       sl_pol = 1'b0;
    logic       eff;
    assign eff = sclk ^ sl_pol;

    sync_master_rx dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk), .sdata_i(sdata), .irq_o(irq)
    );

    always #4ns clk = ~clk;
    always @(posedge clk) cyc++;

    // {pol, nine, wide, divh[7:0], divl[7:0], word[8:0]}
    localparam logic [27:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h01, 9'h1A5},
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 9'h03C},
        {1'b0, 1'b1, 1'b0, 8'h00, 8'h02, 9'h1C3},
        {1'b1, 1'b1, 1'b0, 8'h05, 8'h03, 9'h0FF},
        {1'b0, 1'b0, 1'b1, 8'h00, 8'h04, 9'h081},
        {1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 9'h100}
    };

    // sender: next bit goes out after each leading edge of the shift clock
    initial begin
        forever begin
            @(posedge eff);
            #1ns;
            sdata = sl_words[sl_idx % 8][sl_bit];
            if (sl_bit == sl_nbits - 1) begin
                sl_bit = 0;
                sl_idx++;
            end else begin
                sl_bit++;
            end
        end
    end

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #1200us;
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1ns v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1ns v = bus_rdata;
    endtask

    task automatic wait_ready(input int maxc);
        logic [7:0] s;
        for (int i = 0; i < maxc; i++) begin
            peek(3'd1, s);
            if (s[0]) return;
        end
    endtask

    task automatic sender_reset(input logic pol, input int nbits);
        sl_pol = pol; sl_nbits = nbits; sl_idx = 0; sl_bit = 0;
    endtask

    task automatic half_period(output int hp);
        int t0;
        @(posedge eff); t0 = cyc;
        @(negedge eff); hp = cyc - t0;
    endtask

    initial begin
        logic [7:0] v, s;
        int hp;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11 reset state
        peek(3'd0, v); chk(v == 8'h00, "R11 ctrl", v, 0);
        peek(3'd1, v); chk(v == 8'h00, "R11 stat", v, 0);
        peek(3'd2, v); chk(v == 8'h00, "R11 data", v, 0);
        chk(sclk == 1'b0 && irq == 1'b0, "R11 pins", {sclk, irq}, 0);

        // table walk: one-shot words, R2 R3 R4 R5 R6 R8
        for (int k = 0; k < 6; k++) begin
            logic [27:0] t;
            logic [7:0]  cfg;
            t = VEC[k];
            cfg = {2'b00, 1'b1, t[25], t[27], t[26], 2'b00};
            wr(3'd3, t[16:9]);
            wr(3'd4, t[24:17]);
            wr(3'd0, cfg);
            repeat (2) @(negedge clk);
            sender_reset(t[27], t[26] ? 9 : 8);
            sl_words[0] = t[8:0];
            chk(sclk == t[27], "R2 idle level", sclk, t[27]);
            wr(3'd0, cfg | 8'h01);
            wait_ready(20000);
            chk(irq == 1'b1, "R8 irq raised", irq, 1);
            peek(3'd0, v); chk(v[0] == 1'b0, "R6 one-shot self-clear", v[0], 0);
            peek(3'd1, s);
            chk(s[2] == (t[26] & t[8]), "R4 ninth bit", s[2], t[26] & t[8]);
            rd(3'd2, v); chk(v == t[7:0], "R3 data", v, t[7:0]);
            peek(3'd1, s); chk(s[0] == 1'b0, "R8 read clears flag", s[0], 0);
            chk(irq == 1'b0, "R8 irq drops", irq, 0);
            repeat (3) @(negedge clk);
            chk(sclk == t[27], "R1 idle after word", sclk, t[27]);
        end

        // R1 R5: half period, narrow vs wide divisor with identical bytes
        wr(3'd3, 8'h02); wr(3'd4, 8'h01);
        sender_reset(1'b0, 8); sl_words[0] = 9'h055;
        wr(3'd0, 8'h01);
        half_period(hp); chk(hp == 3, "R5 narrow divisor", hp, 3);
        wait_ready(20000); rd(3'd2, v); chk(v == 8'h55, "R1 data narrow", v, 8'h55);
        sender_reset(1'b0, 8); sl_words[0] = 9'h0AA;
        wr(3'd0, 8'h11);
        half_period(hp); chk(hp == 259, "R5 wide divisor", hp, 259);
        wait_ready(20000); rd(3'd2, v); chk(v == 8'hAA, "R1 data wide", v, 8'hAA);
        wr(3'd4, 8'h00);

        // R8: irq gated off by the enable
        wr(3'd3, 8'h01);
        sender_reset(1'b0, 8); sl_words[0] = 9'h066;
        wr(3'd0, 8'h01);
        wait_ready(2000);
        chk(irq == 1'b0, "R8 irq masked", irq, 0);
        rd(3'd2, v); chk(v == 8'h66, "R8 masked data", v, 8'h66);

        // R7 streaming with prompt reads, then R10 abort mid-word
        wr(3'd3, 8'h03);
        sender_reset(1'b0, 8);
        sl_words[0] = 9'h011; sl_words[1] = 9'h022; sl_words[2] = 9'h033; sl_words[3] = 9'h0FF;
        wr(3'd0, 8'h22);
        for (int k = 0; k < 3; k++) begin
            wait_ready(2000);
            rd(3'd2, v);
            chk(v == 8'(8'h11 * (k + 1)), "R7 stream word", v, 8'h11 * (k + 1));
        end
        repeat (20) @(negedge clk);
        wr(3'd0, 8'h20);
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0, "R10 clock idle after abort", sclk, 0);
        repeat (80) @(negedge clk);
        peek(3'd1, s); chk(s[0] == 1'b0, "R10 partial dropped", s[0], 0);
        sender_reset(1'b0, 8); sl_words[0] = 9'h05A;
        wr(3'd0, 8'h21);
        wait_ready(2000); rd(3'd2, v); chk(v == 8'h5A, "R10 fresh start", v, 8'h5A);

        // R9 overrun
        wr(3'd3, 8'h01);
        sender_reset(1'b0, 8); sl_words[0] = 9'h071; sl_words[1] = 9'h072;
        wr(3'd0, 8'h22);
        wait_ready(2000);
        repeat (100) @(negedge clk);
        peek(3'd1, s); chk(s[1] == 1'b1, "R9 overrun set", s[1], 1);
        v = {7'd0, sclk};
        repeat (20) begin
            @(negedge clk);
            if (sclk != v[0]) v[1] = 1'b1;
        end
        chk(v == 8'h00, "R9 clock halted", v, 0);
        peek(3'd2, v); chk(v == 8'h71, "R9 older word kept", v, 8'h71);
        wr(3'd0, 8'h20);
        peek(3'd1, s); chk(s[1] == 1'b0, "R9 overrun cleared", s[1], 0);
        rd(3'd2, v); chk(v == 8'h71, "R9 data after clear", v, 8'h71);

        // R7 precedence: both enables set
        sender_reset(1'b0, 8); sl_words[0] = 9'h00F; sl_words[1] = 9'h0F0;
        wr(3'd0, 8'h23);
        wait_ready(2000); rd(3'd2, v); chk(v == 8'h0F, "R7 both first", v, 8'h0F);
        peek(3'd0, v); chk(v[0] == 1'b1, "R7 one-shot kept", v[0], 1);
        wait_ready(2000); rd(3'd2, v); chk(v == 8'hF0, "R7 both second", v, 8'hF0);
        wr(3'd0, 8'h00);

        done_flag = 1;
        report();
    end
endmodule